// File: doc/BRIEF.md
# Host-Addressed Configuration Register Bank

This block keeps the setup bytes of a DRAM timing controller. The host has no data bus into the controller. To load a setting, the host performs an access with both the chip select and the configure select low. The eight low address lines of that access supply the byte to store.

An internal write pointer picks the target register. The pointer moves on by one after every load and returns to register 0 after register 10. The host therefore writes the whole bank by issuing eleven configure accesses in a row. The stored bytes are decoded into named fields: a 16-bit refresh interval, the option flags, the five strobe delays, the data-setup delay and two raw bytes.

A `configured` flag rises once register 10 has been written for the first time. It stays high until reset. The sequencer downstream uses this flag to refuse memory requests until every register has received a value.

Top module: `hcfg_top`

## Requirements
- R1: After reset every decoded field is zero, `configured` is low, and `rdy_active_low` is 0, which means the ready output is active high.
- R2: A load occurs on a clock edge where `cs_n` is low, `cs_n` was high at the previous edge, and `conf_n` is low. The register chosen by the pointer then holds `addr_lo`, and that value appears on the outputs after that edge.
- R3: When `cs_n` is held low for several cycles with `conf_n` low, exactly one load takes place.
- R4: No register changes and the pointer does not move in two cases: a falling `cs_n` while `conf_n` is high, and `conf_n` low while `cs_n` stays high.
- R5: Loads fill the registers in this order. Index 0 is the refresh interval low byte and index 1 is its high byte. Index 2 is the option byte, index 3 the data-setup delay and index 4 a spare byte. Indices 5 to 9 are, in turn, the refresh RAS delay, the CAS delay, the RAS-to-CAS delay, the RAS precharge and the CAS precharge. Index 10 is the second option byte.
- R6: After the load into index 10, the pointer wraps, so the next load writes index 0.
- R7: `configured` rises at the edge that writes index 10. It stays high through later loads and wraps, and only reset clears it.
- R8: `refresh_interval` equals {index 1, index 0}, with index 0 as the low byte.
- R9: Option byte bit positions are as follows. Bits [3:0] hold the column-bit code (0 to 8, meaning 1 to 9 column bits), and `col_bits` reports any raw value above 8 as 8. Bit 4 selects active-low ready, bit 5 enables page mode, bit 6 enables the data-setup wait and bit 7 enables the delayed ready.
- R10: A reset in the middle of a sequence returns the pointer to index 0 and clears `configured` and all registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| conf_n | input | 1 | Configure select, active low, synchronous to clk |
| addr_lo | input | 8 | Low host address bits, the data to load |
| refresh_interval | output | 16 | Refresh period code {index 1, index 0} |
| col_bits | output | 4 | Column-bit code, capped at 8 |
| rdy_active_low | output | 1 | Ready output polarity, 1 means active low |
| page_mode_en | output | 1 | Keep the row open between accesses |
| data_setup_en | output | 1 | Insert the data-setup wait |
| rdy_delay_en | output | 1 | Delay the ready assertion |
| data_setup_dly | output | 8 | Data-setup wait length code |
| spare_byte | output | 8 | Spare register, plain storage |
| ras_refresh_dly | output | 8 | RAS low time code for refresh |
| cas_dly | output | 8 | CAS low time code for accesses |
| ras_to_cas_dly | output | 8 | RAS-to-CAS time code |
| ras_pre_dly | output | 8 | RAS precharge time code |
| cas_pre_dly | output | 8 | CAS precharge time code |
| option2_byte | output | 8 | Second option byte, plain storage |
| configured | output | 1 | All registers written since reset |

## Verification
The assertions assume that `cs_n` and `conf_n` are synchronous to `clk` and that both idle high. They also assume that `addr_lo` is stable during the cycle in which a select falls. The bench drives every input on the falling clock edge and releases both selects between loads, so each rising edge sees settled, legal levels. Held-low selects and a configure select without any chip-select fall are applied on purpose, and these stay inside those assumptions.

// File: rtl/hcfg_pkg.sv
package hcfg_pkg;
    localparam int NUM_REGS = 11;
    localparam int REG_W    = 8;
    localparam int PTR_W    = $clog2(NUM_REGS);

    // register order, decoded by the top
    localparam int IDX_REF_LO   = 0;
    localparam int IDX_REF_HI   = 1;
    localparam int IDX_OPT      = 2;
    localparam int IDX_SETUP    = 3;
    localparam int IDX_SPARE    = 4;
    localparam int IDX_RAS_REF  = 5;
    localparam int IDX_CAS      = 6;
    localparam int IDX_RAS2CAS  = 7;
    localparam int IDX_RAS_PRE  = 8;
    localparam int IDX_CAS_PRE  = 9;
    localparam int IDX_OPT2     = 10;

    // option byte layout
    localparam int COL_W        = 4;
    localparam int COL_MAX      = 8;
    localparam int BIT_RDY_LOW  = 4;
    localparam int BIT_PAGE     = 5;
    localparam int BIT_SETUP    = 6;
    localparam int BIT_RDY_DLY  = 7;

    typedef struct packed {
        logic cs_prev;
    } strobe_st_t;
endpackage

// File: rtl/hcfg_strobe.sv
module hcfg_strobe
    import hcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic conf_n,
    output logic load
);
    strobe_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.cs_prev = cs_n;
        load         = !cs_n && st_q.cs_prev && !conf_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cs_prev: 1'b1};
        else        st_q <= st_d;
    end

    // a held-low select cannot produce back-to-back loads
    p_single_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
endmodule

// File: rtl/hcfg_ptr.sv
module hcfg_ptr #(
    parameter int NUM_REGS = hcfg_pkg::NUM_REGS,
    localparam int PTR_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    output logic [PTR_W-1:0] ptr,
    output logic             configured
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             done;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            if (st_q.ptr == LAST) begin
                st_d.ptr  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.ptr  = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr        = st_q.ptr;
    assign configured = st_q.done;

    p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ptr <= LAST);
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && st_q.ptr == LAST) |=> (st_q.ptr == '0));
    p_cfg_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && st_q.ptr == LAST) |=> st_q.done);
    p_cfg_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> st_q.done);
    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.ptr));
endmodule

// File: rtl/hcfg_bank.sv
module hcfg_bank #(
    parameter int NUM_REGS = hcfg_pkg::NUM_REGS,
    parameter int REG_W    = hcfg_pkg::REG_W,
    localparam int PTR_W   = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [PTR_W-1:0]               wsel,
    input  logic [REG_W-1:0]               wdata,
    output logic [NUM_REGS-1:0][REG_W-1:0] regs
);
    logic [NUM_REGS-1:0][REG_W-1:0] bank_d, bank_q;
    logic [NUM_REGS-1:0]            hit;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign hit[g] = we && (wsel == PTR_W'(g));
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) bank_d[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign regs = bank_q;

    p_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(bank_q));
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (bank_q[$past(wsel)] == $past(wdata)));
    p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/hcfg_top.sv
module hcfg_top
    import hcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        conf_n,
    input  logic [7:0]  addr_lo,
    output logic [15:0] refresh_interval,
    output logic [3:0]  col_bits,
    output logic        rdy_active_low,
    output logic        page_mode_en,
    output logic        data_setup_en,
    output logic        rdy_delay_en,
    output logic [7:0]  data_setup_dly,
    output logic [7:0]  spare_byte,
    output logic [7:0]  ras_refresh_dly,
    output logic [7:0]  cas_dly,
    output logic [7:0]  ras_to_cas_dly,
    output logic [7:0]  ras_pre_dly,
    output logic [7:0]  cas_pre_dly,
    output logic [7:0]  option2_byte,
    output logic        configured
);
    logic                           load;
    logic [PTR_W-1:0]               ptr;
    logic [NUM_REGS-1:0][REG_W-1:0] regs;
    logic [REG_W-1:0]               opt;
    logic [COL_W-1:0]               col_raw;

    hcfg_strobe u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .conf_n (conf_n),
        .load   (load)
    );

    hcfg_ptr #(.NUM_REGS(NUM_REGS)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .ptr        (ptr),
        .configured (configured)
    );

    hcfg_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (load),
        .wsel  (ptr),
        .wdata (addr_lo),
        .regs  (regs)
    );

    always_comb begin
        opt              = regs[IDX_OPT];
        col_raw          = opt[COL_W-1:0];
        refresh_interval = {regs[IDX_REF_HI], regs[IDX_REF_LO]};
        col_bits         = (col_raw > COL_W'(COL_MAX)) ? COL_W'(COL_MAX) : col_raw;
        rdy_active_low   = opt[BIT_RDY_LOW];
        page_mode_en     = opt[BIT_PAGE];
        data_setup_en    = opt[BIT_SETUP];
        rdy_delay_en     = opt[BIT_RDY_DLY];
        data_setup_dly   = regs[IDX_SETUP];
        spare_byte       = regs[IDX_SPARE];
        ras_refresh_dly  = regs[IDX_RAS_REF];
        cas_dly          = regs[IDX_CAS];
        ras_to_cas_dly   = regs[IDX_RAS2CAS];
        ras_pre_dly      = regs[IDX_RAS_PRE];
        cas_pre_dly      = regs[IDX_CAS_PRE];
        option2_byte     = regs[IDX_OPT2];
    end

    p_col_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        col_bits <= COL_W'(COL_MAX));
    p_no_cfg_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conf_n && !configured) |=> !configured);
endmodule

// File: tb/hcfg_top_tb.sv
module hcfg_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        conf_n = 1'b1;
    logic [7:0]  addr_lo = '0;
    logic [15:0] refresh_interval;
    logic [3:0]  col_bits;
    logic        rdy_active_low, page_mode_en, data_setup_en, rdy_delay_en;
    logic [7:0]  data_setup_dly, spare_byte, ras_refresh_dly, cas_dly;
    logic [7:0]  ras_to_cas_dly, ras_pre_dly, cas_pre_dly, option2_byte;
    logic        configured;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hcfg_top u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .conf_n(conf_n), .addr_lo(addr_lo),
        .refresh_interval(refresh_interval), .col_bits(col_bits),
        .rdy_active_low(rdy_active_low), .page_mode_en(page_mode_en),
        .data_setup_en(data_setup_en), .rdy_delay_en(rdy_delay_en),
        .data_setup_dly(data_setup_dly), .spare_byte(spare_byte),
        .ras_refresh_dly(ras_refresh_dly), .cas_dly(cas_dly),
        .ras_to_cas_dly(ras_to_cas_dly), .ras_pre_dly(ras_pre_dly),
        .cas_pre_dly(cas_pre_dly), .option2_byte(option2_byte),
        .configured(configured)
    );

    // index order: ref lo, ref hi, option, setup, spare, ras_ref, cas, r2c, ras_pre, cas_pre, opt2
    localparam int NV = 11;
    localparam logic [7:0] VEC [NV] = '{8'h34, 8'h12, 8'hA5, 8'h07, 8'hEE,
                                        8'h03, 8'h02, 8'h01, 8'h04, 8'h05, 8'h04};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [7:0] v);
        @(negedge clk);
        addr_lo = v; cs_n = 1'b0; conf_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; conf_n = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_all_zero(input string req);
        check(req, {16'h0, refresh_interval}, 32'h0);
        check(req, {col_bits, rdy_active_low, page_mode_en, data_setup_en, rdy_delay_en}, 32'h0);
        check(req, {data_setup_dly, spare_byte, ras_refresh_dly, cas_dly}, 32'h0);
        check(req, {ras_to_cas_dly, ras_pre_dly, cas_pre_dly, option2_byte}, 32'h0);
        check(req, {31'h0, configured}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all_zero("R1");

        // R5 R7: walk the vector table, configured only after the last entry
        for (int i = 0; i < NV; i++) begin
            do_load(VEC[i]);
            check("R7", {31'h0, configured}, (i == NV - 1) ? 32'h1 : 32'h0);
        end
        check("R8", {16'h0, refresh_interval}, 32'h1234);
        check("R9", {col_bits, rdy_active_low, page_mode_en, data_setup_en, rdy_delay_en},
              {24'h0, 4'd5, 1'b0, 1'b1, 1'b0, 1'b1});
        check("R5", {data_setup_dly, spare_byte, ras_refresh_dly, cas_dly}, 32'h07EE0302);
        check("R5", {ras_to_cas_dly, ras_pre_dly, cas_pre_dly, option2_byte}, 32'h01040504);

        // R4: chip select falls with configure select high
        @(negedge clk);
        addr_lo = 8'hC3; cs_n = 1'b0; conf_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        // R4: configure select low while chip select stays high
        conf_n = 1'b0;
        repeat (2) @(negedge clk);
        conf_n = 1'b1;
        check("R4", {16'h0, refresh_interval}, 32'h1234);

        // R6 R2: next load wraps to index 0
        do_load(8'h99);
        check("R6", {16'h0, refresh_interval}, 32'h1299);
        check("R7", {31'h0, configured}, 32'h1);

        // R3: held-low select loads once (index 1), index 2 untouched
        @(negedge clk);
        addr_lo = 8'h55; cs_n = 1'b0; conf_n = 1'b0;
        repeat (5) @(negedge clk);
        cs_n = 1'b1; conf_n = 1'b1;
        check("R3", {16'h0, refresh_interval}, 32'h5599);
        check("R3", {24'h0, col_bits, rdy_active_low, page_mode_en, data_setup_en, rdy_delay_en},
              {24'h0, 4'd5, 1'b0, 1'b1, 1'b0, 1'b1});

        // R9: raw column code 12 is capped at 8, other option bits decoded
        do_load(8'h5C);
        check("R9", {col_bits, rdy_active_low, page_mode_en, data_setup_en, rdy_delay_en},
              {24'h0, 4'd8, 1'b1, 1'b0, 1'b1, 1'b0});

        // R10: reset mid-sequence
        do_load(8'h66);
        do_reset();
        check_all_zero("R10");
        do_load(8'h77);
        check("R10", {16'h0, refresh_interval}, 32'h0077);
        check("R10", {31'h0, configured}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule